// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block holds a bank of transmit mailboxes for a CAN-style controller. Each mailbox has an enable bit, a pending-request bit, a 6-bit priority value and a 64-bit frame payload. Software arms mailboxes by writing a mask to the request-set input. While the bus engine is idle, the block picks one pending, enabled mailbox every cycle. The mailbox with the largest priority value wins. When priority values are equal, the higher mailbox number wins. The block offers the winner's index and payload to the bus engine.

The bus engine is modelled as a two-step handshake. A start is accepted on `tx_valid && tx_ready`, and from that cycle the selection is frozen. A later `tx_done` marks the transfer as finished. On `tx_done`, the mailbox's acknowledge flag is set and its request is cleared. Software clears acknowledge flags by writing ones to them. The interrupt output is high while any acknowledge flag is set whose interrupt-mask bit is also set.

Top module: `tx_prio_arbiter`

## Requirements
- R1: After reset, every request, acknowledge, enable, priority and interrupt-mask bit is zero, and `tx_valid` and `irq` are low.
- R2: A cycle with `req_set_we` high ORs `req_set_mask` into `req_pend` (bit i is mailbox i). Bits that are zero in the mask keep their value.
- R3: Only mailboxes with both the enable bit and the request bit set take part in arbitration. A request on a disabled mailbox stays in `req_pend` and competes once the mailbox is enabled.
- R4: Among the eligible mailboxes, the one with the numerically largest priority value (0 to 63) is selected.
- R5: Among eligible mailboxes that share the largest priority value, the highest-numbered one is selected.
- R6: While idle, the selection is recomputed every cycle. `tx_valid` is high exactly when some mailbox is eligible, and `tx_idx` and `tx_payload` show the current winner.
- R7: Once `tx_valid && tx_ready` is accepted, `tx_valid` stays low, and `tx_idx` and `tx_payload` stay on that mailbox until `tx_done` arrives. New requests and priority changes do not alter them.
- R8: `tx_done` while busy sets that mailbox's bit in `ack_flags`, clears its bit in `req_pend`, and returns the block to idle on the next cycle.
- R9: A cycle with `ack_clr_we` high clears the `ack_flags` bits that are set in `ack_clr_mask`. If a completion sets the same bit in the same cycle, the set wins.
- R10: `irq` is high exactly while some bit is set in both `ack_flags` and the interrupt mask.
- R11: If a request-set for a mailbox arrives in the same cycle as that mailbox's `tx_done`, the request stays pending and the acknowledge flag is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Writes the enable bit, priority and payload of mailbox `cfg_sel` |
| cfg_sel | input | IDX_W (5) | Mailbox number for the configuration write |
| cfg_enable | input | 1 | Enable bit value to write |
| cfg_prio | input | PRIO_W (6) | Priority value to write |
| cfg_payload | input | DATA_W (64) | Frame payload to write |
| imask_we | input | 1 | Loads the interrupt mask |
| imask_val | input | NUM_MBOX (32) | New interrupt mask, one bit per mailbox |
| req_set_we | input | 1 | Request-set strobe |
| req_set_mask | input | NUM_MBOX (32) | Mailboxes to arm |
| ack_clr_we | input | 1 | Acknowledge-clear strobe |
| ack_clr_mask | input | NUM_MBOX (32) | Acknowledge bits to clear (write one to clear) |
| tx_ready | input | 1 | Bus engine accepts the offered mailbox |
| tx_done | input | 1 | Bus engine finished the accepted mailbox |
| tx_valid | output | 1 | A mailbox is offered for transmission |
| tx_idx | output | IDX_W (5) | Offered or in-flight mailbox number |
| tx_payload | output | DATA_W (64) | Payload of `tx_idx` |
| req_pend | output | NUM_MBOX (32) | Pending request bits |
| ack_flags | output | NUM_MBOX (32) | Transmit-acknowledge bits |
| irq | output | 1 | Masked acknowledge interrupt |

## Verification
The assertions assume that the bus engine raises `tx_done` only while a transfer is in flight. They also assume that `tx_ready` is looked at only while `tx_valid` is high. The bench drives `tx_done` only after an accepted start, and it pulses `tx_ready` only when it has seen `tx_valid` high. The winner checks assume that priority values do not change in the same cycle they are sampled. The bench changes configuration only through whole-cycle writes that are set up between clock edges.

// File: rtl/txarb_pkg.sv
`timescale 1ns/1ps
package txarb_pkg;
   typedef enum logic {
      ARB_IDLE = 1'b0,
      ARB_BUSY = 1'b1
   } arb_state_e;
endpackage

// File: rtl/mbx_cfg_bank.sv
`timescale 1ns/1ps
module mbx_cfg_bank #(
   parameter int N      = 32,
   parameter int PRIO_W = 6,
   parameter int DATA_W = 64,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_sel,
   input  logic              cfg_enable,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic [DATA_W-1:0] cfg_payload,
   input  logic              imask_we,
   input  logic [N-1:0]      imask_val,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [N-1:0]      en_vec,
   output logic [PRIO_W-1:0] prio_arr [N],
   output logic [N-1:0]      imask,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] data_arr [N];

   for (genvar g = 0; g < N; g++) begin : g_mbx
      logic hit;
      assign hit = cfg_we && (cfg_sel == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_vec[g]   <= 1'b0;
            prio_arr[g] <= '0;
            data_arr[g] <= '0;
         end else if (hit) begin
            en_vec[g]   <= cfg_enable;
            prio_arr[g] <= cfg_prio;
            data_arr[g] <= cfg_payload;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        imask <= '0;
      else if (imask_we) imask <= imask_val;
   end

   assign rd_data = data_arr[rd_idx];
endmodule

// File: rtl/mbx_flags.sv
`timescale 1ns/1ps
module mbx_flags #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic [N-1:0] set_mask,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   input  logic [N-1:0] done_vec,
   output logic [N-1:0] req_q,
   output logic [N-1:0] ack_q
);
   logic [N-1:0] set_eff, clr_eff;

   assign set_eff = set_we ? set_mask : '0;
   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
         ack_q <= '0;
      end else begin
         // a fresh request outranks the completion clear
         req_q <= (req_q & ~done_vec) | set_eff;
         // a completion outranks the software clear
         ack_q <= (ack_q & ~clr_eff) | done_vec;
      end
   end
endmodule

// File: rtl/prio_select.sv
`timescale 1ns/1ps
module prio_select #(
   parameter int N        = 32,
   parameter int PRIO_W   = 6,
   parameter bit USE_TREE = 1'b1,
   localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]      elig,
   input  logic [PRIO_W-1:0] prio_arr [N],
   output logic              found,
   output logic [IDX_W-1:0]  win_idx
);
   if (USE_TREE) begin : g_tree
      localparam int LEAVES = 1 << IDX_W;
      localparam int NODES  = 2 * LEAVES - 1;
      logic              nv [NODES];
      logic [PRIO_W-1:0] np [NODES];
      logic [IDX_W-1:0]  ni [NODES];

      for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
         if (g < N) begin : g_real
            assign nv[LEAVES-1+g] = elig[g];
            assign np[LEAVES-1+g] = prio_arr[g];
         end else begin : g_pad
            assign nv[LEAVES-1+g] = 1'b0;
            assign np[LEAVES-1+g] = '0;
         end
         assign ni[LEAVES-1+g] = IDX_W'(g);
      end

      // right child always covers the higher mailbox numbers
      for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
         logic take_r;
         assign take_r = nv[2*k+2] && (!nv[2*k+1] || (np[2*k+2] >= np[2*k+1]));
         assign nv[k]  = nv[2*k+1] | nv[2*k+2];
         assign np[k]  = take_r ? np[2*k+2] : np[2*k+1];
         assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
      end

      assign found   = nv[0];
      assign win_idx = ni[0];
   end else begin : g_chain
      logic [PRIO_W-1:0] best_p;
      always_comb begin
         found   = 1'b0;
         win_idx = '0;
         best_p  = '0;
         for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || (prio_arr[i] >= best_p))) begin
               found   = 1'b1;
               best_p  = prio_arr[i];
               win_idx = IDX_W'(i);
            end
         end
      end
   end
endmodule

// File: rtl/tx_prio_arbiter.sv
`timescale 1ns/1ps
module tx_prio_arbiter #(
   parameter int NUM_MBOX = 32,
   parameter int PRIO_W   = 6,
   parameter int DATA_W   = 64,
   parameter bit USE_TREE = 1'b1,
   localparam int IDX_W   = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_sel,
   input  logic                cfg_enable,
   input  logic [PRIO_W-1:0]   cfg_prio,
   input  logic [DATA_W-1:0]   cfg_payload,
   input  logic                imask_we,
   input  logic [NUM_MBOX-1:0] imask_val,
   input  logic                req_set_we,
   input  logic [NUM_MBOX-1:0] req_set_mask,
   input  logic                ack_clr_we,
   input  logic [NUM_MBOX-1:0] ack_clr_mask,
   input  logic                tx_ready,
   input  logic                tx_done,
   output logic                tx_valid,
   output logic [IDX_W-1:0]    tx_idx,
   output logic [DATA_W-1:0]   tx_payload,
   output logic [NUM_MBOX-1:0] req_pend,
   output logic [NUM_MBOX-1:0] ack_flags,
   output logic                irq
);
   import txarb_pkg::*;

   if (NUM_MBOX < 2)  begin : g_bad_n  $error("NUM_MBOX must be at least 2"); end
   if (PRIO_W < 1)    begin : g_bad_p  $error("PRIO_W must be at least 1"); end
   if (DATA_W < 1)    begin : g_bad_d  $error("DATA_W must be at least 1"); end

   arb_state_e          st;
   logic [IDX_W-1:0]    cur_idx;
   logic [NUM_MBOX-1:0] en_vec, imask, elig, done_vec;
   logic [PRIO_W-1:0]   prio_arr [NUM_MBOX];
   logic                sel_found;
   logic [IDX_W-1:0]    sel_idx;
   logic                busy;

   mbx_cfg_bank #(.N(NUM_MBOX), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_enable(cfg_enable),
      .cfg_prio(cfg_prio), .cfg_payload(cfg_payload),
      .imask_we(imask_we), .imask_val(imask_val),
      .rd_idx(tx_idx),
      .en_vec(en_vec), .prio_arr(prio_arr), .imask(imask), .rd_data(tx_payload)
   );

   assign elig = req_pend & en_vec;

   prio_select #(.N(NUM_MBOX), .PRIO_W(PRIO_W), .USE_TREE(USE_TREE)) u_sel (
      .elig(elig), .prio_arr(prio_arr), .found(sel_found), .win_idx(sel_idx)
   );

   assign busy     = (st == ARB_BUSY);
   assign tx_valid = !busy && sel_found;
   assign tx_idx   = busy ? cur_idx : sel_idx;
   assign done_vec = (busy && tx_done) ? (NUM_MBOX'(1) << cur_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ARB_IDLE;
         cur_idx <= '0;
      end else begin
         unique case (st)
            ARB_IDLE: if (tx_valid && tx_ready) begin
               st      <= ARB_BUSY;
               cur_idx <= sel_idx;
            end
            ARB_BUSY: if (tx_done) st <= ARB_IDLE;
            default:  st <= ARB_IDLE;
         endcase
      end
   end

   mbx_flags #(.N(NUM_MBOX)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_we(req_set_we), .set_mask(req_set_mask),
      .clr_we(ack_clr_we), .clr_mask(ack_clr_mask),
      .done_vec(done_vec),
      .req_q(req_pend), .ack_q(ack_flags)
   );

   assign irq = |(ack_flags & imask);
endmodule

// File: rtl/tx_prio_arbiter_chk.sv
`timescale 1ns/1ps
module tx_prio_arbiter_chk #(
   parameter int N      = 32,
   parameter int PRIO_W = 6,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              tx_done,
   input logic [IDX_W-1:0]  tx_idx,
   input logic [N-1:0]      elig,
   input logic [PRIO_W-1:0] prio_arr [N],
   input logic [N-1:0]      req_pend,
   input logic [N-1:0]      ack_flags,
   input logic              irq,
   input logic              req_set_we,
   input logic [N-1:0]      req_set_mask,
   input logic              ack_clr_we,
   input logic [N-1:0]      ack_clr_mask
);
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (req_pend == '0) && (ack_flags == '0) && !tx_valid);

   assert_set_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_set_we |=> ((req_pend & $past(req_set_mask)) == $past(req_set_mask)));

   assert_winner_elig_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> elig[tx_idx]);

   always @(posedge clk) begin
      if (rst_n && tx_valid) begin
         for (int j = 0; j < N; j++) begin
            assert_max_prio_R4: assert (!(elig[j] && (prio_arr[j] > prio_arr[tx_idx])))
               else $error("higher priority mailbox %0d skipped", j);
            assert_tie_high_R5: assert (!(elig[j] && (prio_arr[j] == prio_arr[tx_idx])
                                          && (j > int'(tx_idx))))
               else $error("tie lost by higher mailbox %0d", j);
         end
      end
   end

   assert_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (elig != '0)) |-> tx_valid);

   assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> busy);

   assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tx_done) |=> $stable(tx_idx) && !tx_valid);

   assert_done_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_done) |=> ack_flags[$past(tx_idx)] && !busy);

   assert_done_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_done && !(req_set_we && req_set_mask[tx_idx]))
      |=> !req_pend[$past(tx_idx)]);

   assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr_we && !(busy && tx_done)) |=> ((ack_flags & $past(ack_clr_mask)) == '0));

   assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_flags == '0) |-> !irq);

   assert_keep_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_done && req_set_we && req_set_mask[tx_idx]) |=> req_pend[$past(tx_idx)]);
endmodule

bind tx_prio_arbiter tx_prio_arbiter_chk #(.N(NUM_MBOX), .PRIO_W(PRIO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_done(tx_done), .tx_idx(tx_idx),
   .elig(elig), .prio_arr(prio_arr), .req_pend(req_pend), .ack_flags(ack_flags),
   .irq(irq), .req_set_we(req_set_we), .req_set_mask(req_set_mask),
   .ack_clr_we(ack_clr_we), .ack_clr_mask(ack_clr_mask)
);

// File: tb/sim_tx_prio_arbiter.sv
`timescale 1ns/1ps
module sim_tx_prio_arbiter;
   localparam int N = 32;
   localparam int P = 6;
   localparam int D = 64;
   localparam int NV = 6;
   // {request mask, boosted mailbox, boosted priority, expected winner}
   localparam logic [47:0] VEC [NV] = '{
      {32'h0000_0001, 5'd0,  6'd5,  5'd0},
      {32'h8000_0001, 5'd0,  6'd1,  5'd0},
      {32'h0000_00F0, 5'd2,  6'd63, 5'd7},
      {32'hFFFF_FFFF, 5'd10, 6'd63, 5'd10},
      {32'h0001_0100, 5'd16, 6'd0,  5'd16},
      {32'h0000_0006, 5'd1,  6'd2,  5'd1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0, cfg_enable = 0, imask_we = 0, req_set_we = 0, ack_clr_we = 0;
   logic tx_ready = 0, tx_done = 0;
   logic [4:0] cfg_sel = '0;
   logic [P-1:0] cfg_prio = '0;
   logic [D-1:0] cfg_payload = '0;
   logic [N-1:0] imask_val = '0, req_set_mask = '0, ack_clr_mask = '0;
   logic tx_valid, irq;
   logic [4:0] tx_idx;
   logic [D-1:0] tx_payload;
   logic [N-1:0] req_pend, ack_flags;
   int tests = 0, fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   tx_prio_arbiter u0 (.*);

   function automatic logic [D-1:0] pay(int i);
      return {24'hABCDEF, 8'(i), 32'(i * 7 + 1)};
   endfunction

   task automatic tick(); @(posedge clk); #1; endtask

   task automatic chk(string req, logic [D-1:0] act, logic [D-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg(int i, logic en, logic [P-1:0] pr);
      cfg_we = 1; cfg_sel = 5'(i); cfg_enable = en; cfg_prio = pr; cfg_payload = pay(i);
      tick(); cfg_we = 0;
   endtask

   task automatic set_req(logic [N-1:0] m);
      req_set_we = 1; req_set_mask = m; tick(); req_set_we = 0;
   endtask

   task automatic clr_ack(logic [N-1:0] m);
      ack_clr_we = 1; ack_clr_mask = m; tick(); ack_clr_we = 0;
   endtask

   task automatic start_tx(); tx_ready = 1; tick(); tx_ready = 0; endtask
   task automatic finish_tx(); tx_done = 1; tick(); tx_done = 0; endtask

   task automatic do_reset();
      rst_n = 0; tick(); tick(); rst_n = 1; tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 req", D'(req_pend), '0);
      chk("R1 ack", D'(ack_flags), '0);
      chk("R1 valid", D'(tx_valid), 0);
      chk("R1 irq", D'(irq), 0);

      // table of arbitration cases
      for (int v = 0; v < NV; v++) begin
         logic [N-1:0] m;
         logic [4:0] hi, ex;
         logic [P-1:0] hp;
         {m, hi, hp, ex} = VEC[v];
         do_reset();
         for (int i = 0; i < N; i++) cfg(i, 1'b1, '0);
         cfg(int'(hi), 1'b1, hp);
         set_req(m);
         chk("R6 valid", D'(tx_valid), 1);
         chk("R4/R5 winner", D'(tx_idx), D'(ex));
         chk("R6 payload", tx_payload, pay(int'(ex)));
         start_tx();
         chk("R7 valid low", D'(tx_valid), 0);
         finish_tx();
         chk("R8 ack", D'(ack_flags), D'(N'(1) << ex));
         chk("R8 req", D'(req_pend), D'(m & ~(N'(1) << ex)));
      end

      // directed corner cases
      do_reset();
      cfg(3, 1'b0, 6'd9);
      cfg(1, 1'b1, 6'd1);
      set_req(32'h0A);
      chk("R3 disabled skipped", D'(tx_idx), 1);
      chk("R3 stays pending", D'(req_pend), 32'h0A);
      cfg(3, 1'b1, 6'd9);
      chk("R3 enabled now wins", D'(tx_idx), 3);
      cfg(5, 1'b1, 6'd20);
      set_req(32'h20);
      chk("R2 other bits kept", D'(req_pend), 32'h2A);
      chk("R6 reselect", D'(tx_idx), 5);
      start_tx();
      cfg(7, 1'b1, 6'd63);
      set_req(32'h80);
      chk("R7 idx frozen", D'(tx_idx), 5);
      chk("R7 payload frozen", tx_payload, pay(5));
      chk("R7 no offer", D'(tx_valid), 0);
      finish_tx();
      chk("R8 ack5", D'(ack_flags), 32'h20);
      chk("R8 next winner", D'(tx_idx), 7);
      clr_ack(32'h21);
      chk("R9 w1c", D'(ack_flags), 0);
      start_tx();
      tx_done = 1; ack_clr_we = 1; ack_clr_mask = 32'h80; tick();
      tx_done = 0; ack_clr_we = 0;
      chk("R9 set wins", D'(ack_flags), 32'h80);
      chk("R10 masked", D'(irq), 0);
      imask_we = 1; imask_val = 32'h80; tick(); imask_we = 0;
      chk("R10 raised", D'(irq), 1);
      clr_ack(32'h80);
      chk("R10 dropped", D'(irq), 0);
      chk("R4 winner", D'(tx_idx), 3);
      start_tx();
      tx_done = 1; req_set_we = 1; req_set_mask = 32'h08; tick();
      tx_done = 0; req_set_we = 0;
      chk("R11 req kept", D'(req_pend), 32'h0A);
      chk("R11 ack set", D'(ack_flags), 32'h08);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule